// File: doc/BRIEF.md
# Pause frame checker

This block sits behind a receive datapath that has already removed the preamble and start delimiter. It watches a received frame that arrives as 16-bit words, one word on each cycle where `in_valid` is high. `in_sof` marks the first word and `in_eof` marks the last. The block decides whether the frame is a well-formed flow-control pause request. That means it has an accepted destination address, the flow-control type, the pause opcode, exactly 64 bytes, and a correct frame check sequence. When all of these hold, it raises `pause_ok` for one cycle and presents the requested pause time on `pause_quanta` for a downstream timer.

Two destinations are accepted: the reserved flow-control group address and the station's own unicast address. The first three words are therefore checked along two independent match paths, one per address. Either path can drop out at any of those words. The paths merge into a single match state once the address is complete. After that, each word is checked against a word-indexed expected pattern, while a CRC-32 runs over the frame 16 bits per cycle. The first mismatch sends the checker into a discard state, where it stays until the end-of-frame marker.

Top module: `pause_frame_checker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `pause_ok` is 0 and `pause_quanta` is 0.
- R2: A frame is accepted when all of the following hold. It has 32 words. Words 0..2 are 0x0180, 0xC200, 0x0001 (the group address 01-80-C2-00-00-01, with the earlier byte of each word in bits 15:8). Word 6 is 0x8808, word 7 is 0x0001, and the FCS is valid. On acceptance, `pause_ok` is 1 in the cycle after the last word is taken, and `pause_quanta` then equals word 8.
- R3: A frame whose words 0..2 equal `station_mac[47:32]`, `station_mac[31:16]` and `station_mac[15:0]` is accepted like R2. This also holds when the station address shares its leading words with the group address.
- R4: All three destination words must come from one accepted address. A frame that mixes words of the two addresses, or that matches neither address, gives no pulse.
- R5: A frame gives no pulse if word 6 is not 0x8808 or word 7 is not 0x0001. Words 3..5 (source address) and words 9..29 (padding) are never compared, so changing them does not affect acceptance.
- R6: The FCS check works as follows:
  - The CRC is CRC-32 with polynomial 0x04C11DB7 and an all-ones start value.
  - Each byte is fed least significant bit first, and the earlier byte of each word is fed first.
  - Words 30..31 hold the complement of the CRC over words 0..29, least significant byte first.
  - Running the CRC over all 32 words must leave 0xC704DD7B.
  - Any other result gives no pulse.
- R7: A frame with fewer or more than 32 words from `in_sof` to `in_eof` gives no pulse. This includes a one-word frame that has both markers set.
- R8: Valid words that come before any `in_sof` are ignored. Idle cycles (`in_valid` low) may appear inside a frame. An `in_sof` in the middle of a frame abandons that frame and starts checking the new one.
- R9: `pause_ok` is never high for two cycles in a row. `pause_quanta` changes only in a cycle where `pause_ok` is high, and otherwise holds the last accepted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A frame word is present this cycle |
| in_sof | input | 1 | This word is the first of a frame |
| in_eof | input | 1 | This word is the last of a frame |
| in_data | input | 16 | Frame word; the earlier byte on the wire is in bits 15:8 |
| station_mac | input | 48 | Own unicast address; bits 47:40 are the first byte on the wire |
| pause_ok | output | 1 | One-cycle pulse: an accepted pause frame has just ended |
| pause_quanta | output | 16 | Pause time from the last accepted frame |

## Verification
The bench sends complete frames to each of the two addresses, including a station address that shares its first word with the group address. A pass here shows that the two match paths really run independently. It also sends frames that splice words from both addresses, to tell separate per-path tracking apart from a merged "any word matches" test. Frames with a corrupted type, opcode, padding bit or FCS bit separate the pattern compare from the CRC check. Frames that are one word short or one word long, single-word frames, stray words before a start marker, restarts in mid-frame, gapped delivery and back-to-back frames exercise the length counter and the discard state. A behavioural model judges every frame from a queue of its words and is compared with both outputs on every clock.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int unsigned WORD_W      = 16;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BYTES = 64;
  localparam int unsigned FRAME_WORDS = FRAME_BYTES * BYTE_W / WORD_W;
  localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
  localparam int unsigned MAC_W       = 48;
  localparam int unsigned ADDR_WORDS  = MAC_W / WORD_W;
  localparam int unsigned TYPE_POS    = 2 * ADDR_WORDS;
  localparam int unsigned OPC_POS     = TYPE_POS + 1;
  localparam int unsigned TIME_POS    = OPC_POS + 1;
  localparam int unsigned CRC_W       = 32;
  localparam int unsigned FCS_POS     = FRAME_WORDS - CRC_W / WORD_W;
  localparam int unsigned LAST_POS    = FRAME_WORDS - 1;

  localparam logic [MAC_W-1:0]  CTRL_GROUP_MAC = 48'h0180_C200_0001;
  localparam logic [WORD_W-1:0] CTRL_ETHERTYPE = 16'h8808;
  localparam logic [WORD_W-1:0] PAUSE_OPCODE   = 16'h0001;
  localparam logic [CRC_W-1:0]  CRC_POLY       = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0]  CRC_SEED       = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0]  CRC_RESIDUE    = 32'hC704_DD7B;

  // what the pattern decoder says about the word at the current index
  typedef enum logic [2:0] {
    W_DST   = 3'd0,
    W_SRC   = 3'd1,
    W_FIXED = 3'd2,
    W_TIME  = 3'd3,
    W_FILL  = 3'd4,
    W_FCS   = 3'd5
  } wclass_t;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,   // waiting for a start marker
    ST_ADDR = 2'd1,   // inside the destination field, two paths live
    ST_BODY = 2'd2,   // paths merged, single match state
    ST_DROP = 2'd3    // mismatch seen, wait for end marker
  } seq_st_t;

  // One word of CRC-32, MSB-shifting register, bytes taken earlier-first,
  // bits of each byte taken least significant first.
  function automatic logic [CRC_W-1:0] crc_advance(
    input logic [CRC_W-1:0]  seed,
    input logic [WORD_W-1:0] word
  );
    logic [CRC_W-1:0] r;
    logic             fb;
    r = seed;
    for (int i = 0; i < int'(WORD_W); i++) begin
      fb = r[CRC_W-1] ^ word[int'(WORD_W) - 8 - 8 * (i / 8) + (i % 8)];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

endpackage

// File: rtl/pfc_pattern.sv
module pfc_pattern
  import pfc_pkg::*;
(
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [MAC_W-1:0]  own_mac,
  output logic [WORD_W-1:0] want_group,
  output logic [WORD_W-1:0] want_own,
  output logic [WORD_W-1:0] want_fixed,
  output wclass_t           word_kind
);

  logic [WORD_W-1:0] group_tab [ADDR_WORDS];
  logic [WORD_W-1:0] own_tab   [ADDR_WORDS];

  // address words, earliest on the wire at index 0
  for (genvar g = 0; g < int'(ADDR_WORDS); g++) begin : g_addr
    localparam int unsigned HI = MAC_W - 1 - g * WORD_W;
    assign group_tab[g] = CTRL_GROUP_MAC[HI -: WORD_W];
    assign own_tab[g]   = own_mac[HI -: WORD_W];
  end

  always_comb begin
    want_group = '0;
    want_own   = '0;
    for (int k = 0; k < int'(ADDR_WORDS); k++) begin
      if (word_idx == IDX_W'(k)) begin
        want_group = group_tab[k];
        want_own   = own_tab[k];
      end
    end
  end

  always_comb begin
    want_fixed = (word_idx == IDX_W'(OPC_POS)) ? PAUSE_OPCODE : CTRL_ETHERTYPE;
    if (word_idx < IDX_W'(ADDR_WORDS)) begin
      word_kind = W_DST;
    end else if (word_idx < IDX_W'(TYPE_POS)) begin
      word_kind = W_SRC;
    end else if (word_idx <= IDX_W'(OPC_POS)) begin
      word_kind = W_FIXED;
    end else if (word_idx == IDX_W'(TIME_POS)) begin
      word_kind = W_TIME;
    end else if (word_idx < IDX_W'(FCS_POS)) begin
      word_kind = W_FILL;
    end else begin
      word_kind = W_FCS;
    end
  end

endmodule

// File: rtl/pfc_crc_unit.sv
module pfc_crc_unit
  import pfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_en,
  input  logic              frame_start,
  input  logic [WORD_W-1:0] word,
  output logic              residue_good
);

  logic [CRC_W-1:0] acc_q;
  logic [CRC_W-1:0] acc_d;

  always_comb begin
    acc_d = crc_advance(frame_start ? CRC_SEED : acc_q, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= CRC_SEED;
    end else if (word_en) begin
      acc_q <= acc_d;
    end
  end

  // includes the current word, so valid on the final word of the frame
  assign residue_good = (acc_d == CRC_RESIDUE);

endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] want_group,
  input  logic [WORD_W-1:0] want_own,
  input  logic [WORD_W-1:0] want_fixed,
  input  wclass_t           word_kind,
  input  logic              residue_good,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_pass,
  output logic [WORD_W-1:0] frame_time
);

  seq_st_t           st_q,  st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              grp_q, grp_d;
  logic              own_q, own_d;
  logic [WORD_W-1:0] tm_q,  tm_d;

  logic live, grp_hit, own_hit, word_ok, at_last;

  assign word_idx   = in_sof ? '0 : idx_q;
  assign frame_time = tm_q;

  always_comb begin
    live    = in_sof || (st_q == ST_ADDR) || (st_q == ST_BODY);
    // a start marker re-arms both address paths
    grp_hit = (in_sof || grp_q) && (in_data == want_group);
    own_hit = (in_sof || own_q) && (in_data == want_own);
    at_last = (word_idx == IDX_W'(LAST_POS));
    unique case (word_kind)
      W_DST:   word_ok = grp_hit || own_hit;
      W_FIXED: word_ok = (in_data == want_fixed);
      default: word_ok = 1'b1;
    endcase
  end

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    grp_d      = grp_q;
    own_d      = own_q;
    tm_d       = tm_q;
    frame_pass = 1'b0;
    if (in_valid) begin
      if (live) begin
        idx_d = word_idx + 1'b1;
        grp_d = grp_hit;
        own_d = own_hit;
        if (word_kind == W_TIME) begin
          tm_d = in_data;
        end
        if (in_eof) begin
          st_d       = ST_HUNT;
          frame_pass = word_ok && at_last && residue_good;
        end else if (!word_ok || at_last) begin
          st_d = ST_DROP;
        end else if (word_idx < IDX_W'(ADDR_WORDS - 1)) begin
          st_d = ST_ADDR;
        end else begin
          st_d = ST_BODY;
        end
      end else if ((st_q == ST_DROP) && in_eof) begin
        st_d = ST_HUNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      idx_q <= '0;
      grp_q <= 1'b0;
      own_q <= 1'b0;
      tm_q  <= '0;
    end else if (in_valid) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      grp_q <= grp_d;
      own_q <= own_d;
      tm_q  <= tm_d;
    end
  end

endmodule

// File: rtl/pause_frame_checker.sv
module pause_frame_checker
  import pfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [WORD_W-1:0] in_data,
  input  logic [MAC_W-1:0]  station_mac,
  output logic              pause_ok,
  output logic [WORD_W-1:0] pause_quanta
);

  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] want_group, want_own, want_fixed;
  wclass_t           word_kind;
  logic              residue_good;
  logic              frame_pass;
  logic [WORD_W-1:0] frame_time;
  logic              ok_d;
  logic [WORD_W-1:0] quanta_d;

  pfc_pattern u_pattern (
    .word_idx   (word_idx),
    .own_mac    (station_mac),
    .want_group (want_group),
    .want_own   (want_own),
    .want_fixed (want_fixed),
    .word_kind  (word_kind)
  );

  pfc_crc_unit u_crc (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_en      (in_valid),
    .frame_start  (in_sof),
    .word         (in_data),
    .residue_good (residue_good)
  );

  pfc_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .in_data      (in_data),
    .want_group   (want_group),
    .want_own     (want_own),
    .want_fixed   (want_fixed),
    .word_kind    (word_kind),
    .residue_good (residue_good),
    .word_idx     (word_idx),
    .frame_pass   (frame_pass),
    .frame_time   (frame_time)
  );

  always_comb begin
    ok_d     = in_valid && frame_pass;
    quanta_d = ok_d ? frame_time : pause_quanta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_ok     <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_ok     <= ok_d;
      pause_quanta <= quanta_d;
    end
  end

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
  import pfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic              pause_ok,
  input logic [WORD_W-1:0] pause_quanta
);

  // independent word count since the last start marker (saturating)
  logic [6:0] seen_q;
  logic [6:0] seen_now;
  logic       len_hit_q;

  assign seen_now = in_sof ? 7'd1 : seen_q + 7'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= '0;
      len_hit_q <= 1'b0;
    end else begin
      if (in_valid && (seen_now != 7'd0)) begin
        seen_q <= seen_now;
      end
      len_hit_q <= in_valid && in_eof && (seen_now == 7'(FRAME_WORDS));
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!pause_ok && (pause_quanta == '0)));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pause_ok |=> !pause_ok);

  a_r9_quanta_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_ok |-> $stable(pause_quanta));

  a_r2_after_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    pause_ok |-> $past(in_valid && in_eof));

  a_r7_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
    pause_ok |-> len_hit_q);

endmodule

bind pause_frame_checker pfc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_sof       (in_sof),
  .in_eof       (in_eof),
  .pause_ok     (pause_ok),
  .pause_quanta (pause_quanta)
);

// File: tb/sim_pause_frame_checker.sv
module sim_pause_frame_checker;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [15:0] in_data;
  logic [47:0] mac;
  logic        pause_ok;
  logic [15:0] pause_quanta;

  localparam logic [47:0] GROUP = 48'h0180_C200_0001;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    pulses = 0;
  string cur_req = "R1";

  pause_frame_checker u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sof (in_sof),
    .in_eof (in_eof), .in_data (in_data), .station_mac (mac),
    .pause_ok (pause_ok), .pause_quanta (pause_quanta)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [31:0] crc_refl(input logic [15:0] w[$], input int n);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int h = 0; h < 2; h++) begin
        b = (h == 0) ? w[i][15:8] : w[i][7:0];
        c = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
    end
    return c;
  endfunction

  function automatic bit frame_good(input logic [15:0] q[$]);
    logic [47:0] d;
    if (q.size() != 32) return 1'b0;
    d = {q[0], q[1], q[2]};
    if (d != GROUP && d != mac) return 1'b0;
    if (q[6] != 16'h8808 || q[7] != 16'h0001) return 1'b0;
    return crc_refl(q, 32) == 32'hDEBB_20E3;
  endfunction

  logic        exp_ok;
  logic [15:0] exp_q;
  logic [15:0] mq[$];
  bit          m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_ok <= 1'b0;
      exp_q  <= 16'h0;
      m_act  = 1'b0;
      mq.delete();
    end else begin
      exp_ok <= 1'b0;
      if (in_valid) begin
        if (in_sof) begin
          mq.delete();
          m_act = 1'b1;
        end
        if (m_act) mq.push_back(in_data);
        if (in_eof && m_act) begin
          m_act = 1'b0;
          if (frame_good(mq)) begin
            exp_ok <= 1'b1;
            exp_q  <= mq[8];
          end
        end
      end
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #1;
    check(cur_req, "pause_ok", {31'b0, pause_ok}, {31'b0, exp_ok});
    check(cur_req, "pause_quanta", {16'b0, pause_quanta}, {16'b0, exp_q});
    if (pause_ok === 1'b1) pulses++;
  end

  // ---------------- stimulus helpers ----------------
  logic [15:0] frm[$];

  task automatic seal();
    logic [31:0] f;
    f = ~crc_refl(frm, 30);
    frm[30] = {f[7:0], f[15:8]};
    frm[31] = {f[23:16], f[31:24]};
  endtask

  task automatic make_frame(input logic [47:0] dst, input logic [15:0] typ,
                            input logic [15:0] op, input logic [15:0] pt, input int seed);
    frm.delete();
    frm.push_back(dst[47:32]); frm.push_back(dst[31:16]); frm.push_back(dst[15:0]);
    for (int i = 0; i < 3; i++) frm.push_back(16'(seed * 4099 + i * 77));
    frm.push_back(typ);
    frm.push_back(op);
    frm.push_back(pt);
    for (int i = 0; i < 21; i++) frm.push_back(16'(seed * 37 + i * 101));
    frm.push_back(16'h0);
    frm.push_back(16'h0);
    seal();
  endtask

  task automatic put(input bit s, input bit e, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
  endtask

  task automatic rest(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 16'h0;
    end
  endtask

  task automatic play(input int n, input int gap_every);
    for (int i = 0; i < n; i++) begin
      put(i == 0, i == n - 1, frm[i]);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1 && i != n - 1) rest(1);
    end
  endtask

  task automatic run_frame(input string req, input int n, input int gap, input int want);
    int p0;
    cur_req = req;
    p0 = pulses;
    play(n, gap);
    rest(3);
    check(req, "pulse count", pulses - p0, want);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL %s watchdog expired: actual hung expected done", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- tests ----------------
  initial begin
    logic [15:0] held;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 16'h0;
    mac   = 48'h0024_8C11_22A3;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "reset pause_ok", {31'b0, pause_ok}, 32'd0);
    check("R1", "reset quanta", {16'b0, pause_quanta}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release pause_ok", {31'b0, pause_ok}, 32'd0);
    rest(2);

    // R2: group address
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h1234, 1);
    run_frame("R2", 32, 0, 1);
    check("R2", "quanta", {16'b0, pause_quanta}, 32'h1234);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'hFFFF, 2);
    run_frame("R2", 32, 0, 1);
    check("R2", "quanta max", {16'b0, pause_quanta}, 32'hFFFF);

    // R3: own address, then own address sharing first word with group
    make_frame(mac, 16'h8808, 16'h0001, 16'hBEEF, 3);
    run_frame("R3", 32, 0, 1);
    check("R3", "quanta", {16'b0, pause_quanta}, 32'hBEEF);
    mac = 48'h0180_C2AB_CD01;
    rest(1);
    make_frame(mac, 16'h8808, 16'h0001, 16'h0042, 4);
    run_frame("R3", 32, 0, 1);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0043, 5);
    run_frame("R3", 32, 0, 1);

    // R4: spliced or foreign destinations
    make_frame(48'h0180_C200_CD01, 16'h8808, 16'h0001, 16'h0101, 6);
    run_frame("R4", 32, 0, 0);
    make_frame(48'h0180_C2AB_0001, 16'h8808, 16'h0001, 16'h0102, 7);
    run_frame("R4", 32, 0, 0);
    make_frame(48'hFFFF_FFFF_FFFF, 16'h8808, 16'h0001, 16'h0103, 8);
    run_frame("R4", 32, 0, 0);
    check("R4", "quanta unchanged", {16'b0, pause_quanta}, 32'h0043);

    // R5: type and opcode compared; source and padding not
    make_frame(GROUP, 16'h8809, 16'h0001, 16'h0200, 9);
    run_frame("R5", 32, 0, 0);
    make_frame(GROUP, 16'h8808, 16'h0002, 16'h0201, 10);
    run_frame("R5", 32, 0, 0);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0202, 999);
    run_frame("R5", 32, 0, 1);

    // R6: CRC failures
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0300, 11);
    frm[15] = frm[15] ^ 16'h0001;
    run_frame("R6", 32, 0, 0);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0301, 12);
    frm[31] = frm[31] ^ 16'h8000;
    run_frame("R6", 32, 0, 0);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0302, 13);
    frm[4] = frm[4] ^ 16'h0100;
    run_frame("R6", 32, 0, 0);

    // R7: wrong lengths
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0400, 14);
    run_frame("R7", 31, 0, 0);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0401, 15);
    frm.push_back(16'hA5A5);
    run_frame("R7", 33, 0, 0);
    cur_req = "R7";
    put(1'b1, 1'b1, 16'h0180);
    rest(3);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0402, 16);
    run_frame("R7", 32, 0, 1);

    // R8: stray words, gaps, restart
    cur_req = "R8";
    for (int i = 0; i < 5; i++) put(1'b0, 1'b0, 16'h0180);
    put(1'b0, 1'b1, 16'hDEAD);
    rest(3);
    check("R8", "stray words quanta", {16'b0, pause_quanta}, 32'h0402);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0500, 17);
    run_frame("R8", 32, 3, 1);
    make_frame(GROUP, 16'h8808, 16'h0001, 16'h0501, 18);
    cur_req = "R8";
    for (int i = 0; i < 10; i++) put(i == 0, 1'b0, frm[i]);
    make_frame(mac, 16'h8808, 16'h0001, 16'h0502, 19);
    run_frame("R8", 32, 0, 1);
    check("R8", "restart quanta", {16'b0, pause_quanta}, 32'h0502);

    // R9: hold across a reject, then back-to-back accepts
    held = pause_quanta;
    make_frame(GROUP, 16'h8809, 16'h0001, 16'h0600, 20);
    run_frame("R9", 32, 0, 0);
    check("R9", "held quanta", {16'b0, pause_quanta}, {16'b0, held});
    cur_req = "R9";
    begin
      int p0;
      p0 = pulses;
      make_frame(GROUP, 16'h8808, 16'h0001, 16'h0601, 21);
      play(32, 0);
      make_frame(mac, 16'h8808, 16'h0001, 16'h0602, 22);
      play(32, 0);
      rest(3);
      check("R9", "back-to-back pulses", pulses - p0, 2);
      check("R9", "last quanta", {16'b0, pause_quanta}, 32'h0602);
    end

    rest(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule